// File: doc/BRIEF.md
# Counter Compare Interrupt Timer

This block keeps a free-running counter and two compare channels that share it. Each channel holds one register whose top bit is an interrupt-disable flag and whose lower bits are the value the counter is matched against. When the counter reaches that value and the channel is enabled, the supervisor channel emits a one-cycle pulse that sets the timer bit (bit 16) of a soft-interrupt pending register kept elsewhere. The hypervisor channel instead sets a one-bit pending flag kept inside this block, and that flag drives the hypervisor interrupt request.

Software reaches the two compare registers and the pending flag through a simple register bus with a one-cycle read latency. Rewriting a compare register replaces the armed value: a match due on the old value in the same cycle is dropped, and the channel watches for the new value. Reset leaves both channels disabled.

Top module: `cmp_intr_timer`

## Requirements
- R1: While reset is held and in the cycle after it is released, both compare registers read as disable bit (top bit) 1 with match value 0, the pending flag reads 0, and both `tick_set_o` and `hv_irq_o` are low.
- R2: The counter is 0 while reset is held, advances by one on every clock edge after reset, and wraps from all ones to 0; a match value of all ones therefore pulses in the cycle the counter has returned to 0.
- R3: When the counter equals the supervisor match value (register 0, lower `CNT_W` bits) and its top bit is 0, `tick_set_o` is high for exactly the next cycle.
- R4: When the counter equals the hypervisor match value (register 1) and its top bit is 0, the pending flag becomes 1 in the next cycle and stays 1 until software clears it.
- R5: A channel whose top bit is 1 produces no pulse and no pending flag update, whatever the counter value.
- R6: An enabled channel fires once per counter period: one event per wrap of the counter, spaced exactly 2^`CNT_W` cycles apart.
- R7: A bus write to a compare register in the cycle its match occurs cancels that match; the new value is armed and fires when the counter reaches it.
- R8: A write to the pending flag (address 2, bit 0) loads bit 0; a hypervisor match in the same cycle as a write of 0 still leaves the flag at 1.
- R9: Address map, 2-bit address: 0 supervisor compare, 1 hypervisor compare, 2 pending flag in bit 0 with upper bits 0, 3 reads 0 and ignores writes. `bus_rdata` shows, one cycle after the address is presented, the register value from the cycle the address was presented.
- R10: `hv_irq_o` is high exactly while the pending flag is 1 and goes low in the cycle after software writes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W+1 | Write data |
| bus_rdata | output | CNT_W+1 | Registered read data |
| tick_set_o | output | 1 | One-cycle pulse that sets the soft-interrupt timer bit |
| hv_irq_o | output | 1 | Hypervisor interrupt request |

## Verification
The bench builds the block with `CNT_W` = 8 instead of the default 63, so a full counter period is 256 cycles. That puts the wrap from all ones to zero, repeated firing across several periods, and a match at the largest value within a few hundred cycles. The bench keeps its own model of the counter from reset, which lets it place bus writes exactly in a match cycle to exercise cancellation and the write-versus-match priority of the pending flag.

// File: rtl/cmp_intr_timer_pkg.sv
package cmp_intr_timer_pkg;

  localparam int ADDR_W = 2;
  localparam int NUM_CH = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_SUP_CMP = 2'd0,
    A_HYP_CMP = 2'd1,
    A_HYP_PND = 2'd2,
    A_UNUSED  = 2'd3
  } reg_addr_e;

  localparam int CH_SUP = 0;
  localparam int CH_HYP = 1;

endpackage

// File: rtl/cit_counter.sv
module cit_counter #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/cit_channel.sv
module cit_channel #(
  parameter int CNT_W = 63,
  localparam int DW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [DW-1:0]    cmp_o,
  output logic             fire_o
);

  localparam logic [DW-1:0] CMP_RST = {1'b1, {CNT_W{1'b0}}};

  logic [DW-1:0] cmp_q;
  logic          hit;
  logic          off;

  always_ff @(posedge clk) begin
    if (rst)       cmp_q <= CMP_RST;
    else if (wr_i) cmp_q <= wdata_i;
  end

  assign off    = cmp_q[CNT_W];
  assign hit    = (cnt_i == cmp_q[CNT_W-1:0]);
  // a rewrite in the match cycle drops the match armed on the old value
  assign fire_o = hit & ~off & ~wr_i;
  assign cmp_o  = cmp_q;

  // R1
  cmp_reset_chk: assert property (@(posedge clk)
    rst |=> cmp_q == CMP_RST);

endmodule

// File: rtl/cmp_intr_timer.sv
module cmp_intr_timer
  import cmp_intr_timer_pkg::*;
#(
  parameter int CNT_W = 63,
  localparam int DW   = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tick_set_o,
  output logic              hv_irq_o
);

  logic [CNT_W-1:0]  cnt;
  logic [DW-1:0]     cmp   [NUM_CH];
  logic [NUM_CH-1:0] fire;
  logic [NUM_CH-1:0] ch_wr;

  logic          pend_q;
  logic          pend_d;
  logic          pend_wr;
  logic          tick_q;
  logic [DW-1:0] rdata_q;

  cit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_wr[g] = bus_we && (bus_addr == ADDR_W'(g));
    cit_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (ch_wr[g]),
      .wdata_i (bus_wdata),
      .cnt_i   (cnt),
      .cmp_o   (cmp[g]),
      .fire_o  (fire[g])
    );
  end

  assign pend_wr = bus_we && (bus_addr == A_HYP_PND);

  // a write of 1 wins trivially; a write of 0 loses to a same-cycle match
  always_comb begin
    if (pend_wr) pend_d = bus_wdata[0] | fire[CH_HYP];
    else         pend_d = pend_q | fire[CH_HYP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      tick_q <= fire[CH_SUP];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (bus_addr)
        A_SUP_CMP: rdata_q <= cmp[CH_SUP];
        A_HYP_CMP: rdata_q <= cmp[CH_HYP];
        A_HYP_PND: rdata_q <= {{CNT_W{1'b0}}, pend_q};
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata  = rdata_q;
  assign tick_set_o = tick_q;
  assign hv_irq_o   = pend_q;

  // R1
  out_reset_chk: assert property (@(posedge clk)
    rst |=> (!tick_set_o && !hv_irq_o));

  // R3
  tick_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tick_set_o) |->
      ($past(cnt) == $past(cmp[CH_SUP][CNT_W-1:0])));

  // R5
  tick_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmp[CH_SUP][CNT_W])) |-> !tick_set_o);

  // R6
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_set_o |=> !tick_set_o);

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !pend_wr) |=> pend_q);

  // R8
  pend_wr1_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_wr && bus_wdata[0]) |=> pend_q);

endmodule

// File: tb/cmp_intr_timer_tb.sv
module cmp_intr_timer_tb;

  localparam int CW = 8;
  localparam int DW = CW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          tick_set_o;
  logic          hv_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [CW-1:0] bcnt;

  always #5 clk = ~clk;

  cmp_intr_timer #(.CNT_W(CW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tick_set_o (tick_set_o),
    .hv_irq_o   (hv_irq_o)
  );

  // model of the free-running counter per R2
  always @(posedge clk) begin
    if (rst) bcnt <= '0;
    else     bcnt <= bcnt + 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_cnt(input logic [CW-1:0] v);
    while (bcnt != v) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk(tick_set_o == 1'b0, "R1 tick in reset", tick_set_o, 0);
    chk(hv_irq_o == 1'b0, "R1 irq in reset", hv_irq_o, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(tick_set_o == 1'b0 && hv_irq_o == 1'b0, "R1 outputs after reset",
        {tick_set_o, hv_irq_o}, 0);
    bus_read(2'd0, d); chk(d == 9'h100, "R1 sup cmp reset", d, 9'h100);
    bus_read(2'd1, d); chk(d == 9'h100, "R1 hyp cmp reset", d, 9'h100);
    bus_read(2'd2, d); chk(d == 9'h000, "R1 pend reset", d, 0);
  endtask

  task automatic t_sup_match;
    bus_write(2'd0, {1'b0, 8'd50});
    wait_cnt(8'd50);
    chk(tick_set_o == 1'b0, "R3 no pulse in match cycle", tick_set_o, 0);
    @(negedge clk);
    chk(tick_set_o == 1'b1, "R3 pulse after match", tick_set_o, 1);
    @(negedge clk);
    chk(tick_set_o == 1'b0, "R3 pulse one cycle", tick_set_o, 0);
  endtask

  task automatic t_once_per_wrap;
    int pulses = 0;
    int first = -1;
    int gap = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (tick_set_o) begin
        if (first >= 0) gap = i - first;
        else first = i;
        pulses++;
      end
    end
    chk(pulses == 2, "R6 pulses in two periods", pulses, 2);
    chk(gap == 256, "R6 pulse spacing", gap, 256);
  endtask

  task automatic t_wrap_edge;
    bus_write(2'd0, {1'b0, 8'hFF});
    wait_cnt(8'hFF);
    @(negedge clk);
    chk(bcnt == 8'd0 && tick_set_o == 1'b1, "R2 wrap match pulses at count 0",
        tick_set_o, 1);
  endtask

  task automatic t_disable;
    int pulses = 0;
    bus_write(2'd0, {1'b1, 8'd70});
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tick_set_o) pulses++;
    end
    chk(pulses == 0, "R5 disabled supervisor channel", pulses, 0);
  endtask

  task automatic t_cancel;
    int pulses = 0;
    bus_write(2'd0, {1'b0, 8'd100});
    wait_cnt(8'd100);
    bus_write(2'd0, {1'b0, 8'd110});
    chk(tick_set_o == 1'b0, "R7 old match cancelled", tick_set_o, 0);
    while (bcnt != 8'd111) begin
      @(negedge clk);
      if (tick_set_o) pulses++;
    end
    chk(pulses == 1 && tick_set_o == 1'b1, "R7 new value fires", pulses, 1);
    bus_write(2'd0, {1'b1, 8'd0});
  endtask

  task automatic t_hyp;
    logic [DW-1:0] d;
    bus_write(2'd1, {1'b0, 8'd60});
    wait_cnt(8'd60);
    chk(hv_irq_o == 1'b0, "R4 no irq in match cycle", hv_irq_o, 0);
    @(negedge clk);
    chk(hv_irq_o == 1'b1, "R4 irq after match", hv_irq_o, 1);
    bus_read(2'd2, d);
    chk(d == 9'h001, "R9 pend reads 1", d, 1);
    bus_write(2'd1, {1'b1, 8'd60});
    repeat (300) @(negedge clk);
    chk(hv_irq_o == 1'b1, "R4 pend held", hv_irq_o, 1);
    bus_write(2'd2, 9'h000);
    chk(hv_irq_o == 1'b0, "R10 irq withdrawn on clear", hv_irq_o, 0);
  endtask

  task automatic t_hyp_disable;
    bus_write(2'd1, {1'b1, 8'd20});
    wait_cnt(8'd20);
    repeat (3) @(negedge clk);
    chk(hv_irq_o == 1'b0, "R5 disabled hypervisor channel", hv_irq_o, 0);
  endtask

  task automatic t_pend_write;
    bus_write(2'd2, 9'h001);
    chk(hv_irq_o == 1'b1, "R8 write 1 sets pend", hv_irq_o, 1);
    bus_write(2'd2, 9'h000);
    chk(hv_irq_o == 1'b0, "R8 write 0 clears pend", hv_irq_o, 0);
    bus_write(2'd1, {1'b0, 8'd80});
    wait_cnt(8'd80);
    bus_write(2'd2, 9'h000);
    chk(hv_irq_o == 1'b1, "R8 match beats write 0", hv_irq_o, 1);
    bus_write(2'd1, {1'b1, 8'd80});
    bus_write(2'd2, 9'h000);
    chk(hv_irq_o == 1'b0, "R10 irq low after clear", hv_irq_o, 0);
  endtask

  task automatic t_map;
    logic [DW-1:0] d;
    bus_write(2'd1, {1'b1, 8'hA5});
    bus_write(2'd0, {1'b1, 8'h3C});
    bus_write(2'd3, 9'h1FF);
    bus_read(2'd3, d); chk(d == 9'h000, "R9 addr 3 reads 0", d, 0);
    bus_read(2'd0, d); chk(d == 9'h13C, "R9 sup readback", d, 9'h13C);
    bus_read(2'd1, d); chk(d == 9'h1A5, "R9 hyp readback", d, 9'h1A5);
    bus_read(2'd2, d); chk(d == 9'h000, "R9 addr 3 write ignored", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sup_match();
    t_once_per_wrap();
    t_wrap_edge();
    t_disable();
    t_cancel();
    t_hyp();
    t_hyp_disable();
    t_pend_write();
    t_map();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule